// File: doc/BRIEF.md
# Unlock-Protected Flash Command Sequence Decoder

This block sits behind the write port of a word-wide flash array model or controller. It watches single-cycle bus writes, each carrying a word address and a 16-bit data word. It recognises the write sequences that software must issue before the array may be altered. Every alteration must begin with a two-write unlock key. A program adds a command write and then one address/data write. An erase adds an erase-setup command, a second unlock key and a final erase-select write. The same key followed by other command codes switches the read path into identification mode or parameter-query mode, and an exit code returns it to normal reads.

When a sequence completes, the block raises `op_start` for exactly one clock. In the same cycle it presents the operation kind, the target address aligned to the erase granule, and the data word of the completing write. A timer elsewhere runs the operation and reports it through `busy`. While `busy` is high, every write is ignored. During identification mode the block also returns the identification word for the read address parity on `rd_a0`.

The sequencer has seven states:
- `ST_IDLE`: waits for the first key write.
- `ST_KEY1`: waits for the second key write.
- `ST_CMD`: waits for the command write.
- `ST_PROG`: waits for the program address and data.
- `ST_EKEY0` and `ST_EKEY1`: wait for the repeated key after erase setup.
- `ST_ECMD`: waits for the erase-select write.

The transitions are as follows:
- A matching write advances one state.
- In `ST_CMD`, a program code goes to `ST_PROG` and an erase-setup code goes to `ST_EKEY0`. Identification, query and exit codes go back to `ST_IDLE` and set the mode.
- `ST_PROG` and a valid erase select in `ST_ECMD` launch an operation and go back to `ST_IDLE`.
- Any write that does not match its step goes to `ST_IDLE` with the mode set to read.

A separate mode register holds READ, ID or CFI.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After reset the block is in read mode (`mode_read`=1, the others 0) with no partial sequence pending. `op_start`=0, and `op_kind`, `op_addr` and `op_data` are 0.
- R2: A program sequence launches the operation. The sequence is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555, then any address/data write. One cycle after the last write, `op_start`=1 for one cycle, `op_kind`=1, `op_addr` is the full write address and `op_data` is the full write data. Both are held until the next launch.
- R3: Key and command matching compares only address bits 14..0 and data bits 7..0. Upper address and data bits do not affect the match.
- R4: The erase key is the unlock pair, then 0x80 at 0x5555, then the unlock pair again, then a sixth write. If the sixth write has data 0x30 at any address, the block launches `op_kind`=2 (sector). `op_addr` is the write address with bits below SECTOR_LSB (default 11) cleared.
- R5: A sixth erase write with data 0x50 launches `op_kind`=3 (block). `op_addr` is the address with bits below BLOCK_LSB (default 15) cleared.
- R6: A sixth erase write with data 0x10 at address 0x5555 launches `op_kind`=4 (chip) with `op_addr`=0. Data 0x10 at any other address launches nothing and returns to read mode.
- R7: The unlock pair followed by 0x90 at 0x5555 enters ID mode (`mode_id`=1). In ID mode `id_word` is 0x00BF when `rd_a0`=0 and DEV_CODE when `rd_a0`=1. Outside ID mode `id_word` is 0.
- R8: The unlock pair followed by 0x98 at 0x5555 enters CFI mode (`mode_cfi`=1).
- R9: Either a single write of 0xF0 at any address or the unlock pair followed by 0xF0 at 0x5555 returns ID or CFI mode to read mode.
- R10: A write that does not match the expected step aborts the partial sequence, sets read mode and launches nothing. The next sequence must start again from the first key write.
- R11: A write while `busy`=1 is ignored entirely, including an exit write. The mode, any partial sequence and `op_start` are unaffected.
- R12: Exactly one mode flag is high in every cycle, and `op_start` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Data word of the write |
| busy | input | 1 | Internal program/erase in progress |
| rd_a0 | input | 1 | Bit 0 of the current read address |
| op_start | output | 1 | One-cycle launch pulse |
| op_kind | output | 3 | 1 program, 2 sector erase, 3 block erase, 4 chip erase |
| op_addr | output | ADDR_W | Target address, aligned for erases |
| op_data | output | 16 | Data of the completing write |
| mode_read | output | 1 | Normal array read mode |
| mode_id | output | 1 | Identification mode |
| mode_cfi | output | 1 | Parameter-query mode |
| id_word | output | 16 | Identification word in ID mode, else 0 |

## Verification
A corrupted sequencer state stays invisible until the next accepted write. That write then either launches a spurious or missing operation, or flips a mode flag. The error therefore reaches `op_start`, `op_kind`/`op_addr` or the mode flags exactly one clock after that write. The bench's behavioural model keeps the accepted writes of the pending sequence in a queue and matches them by position. Outputs are compared against the model in every cycle, so any divergence is reported within one clock of the write that exposes it. Aborts, busy-blocked exits and erase selects at the wrong address are driven explicitly.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam int KEY_W = 15;

    localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] CODE_KEY_A = 8'hAA;
    localparam logic [7:0] CODE_KEY_B = 8'h55;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_ERASE = 8'h80;
    localparam logic [7:0] CODE_ID    = 8'h90;
    localparam logic [7:0] CODE_CFI   = 8'h98;
    localparam logic [7:0] CODE_SECT  = 8'h30;
    localparam logic [7:0] CODE_BLK   = 8'h50;
    localparam logic [7:0] CODE_CHIP  = 8'h10;

    localparam logic [15:0] MFR_CODE  = 16'h00BF;

    typedef enum logic [2:0] {
        OPK_NONE   = 3'd0,
        OPK_PROG   = 3'd1,
        OPK_SECTOR = 3'd2,
        OPK_BLOCK  = 3'd3,
        OPK_CHIP   = 3'd4
    } op_kind_e;

    typedef enum logic [1:0] {
        MD_READ = 2'd0,
        MD_ID   = 2'd1,
        MD_CFI  = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_CMD,
        ST_PROG,
        ST_EKEY0,
        ST_EKEY1,
        ST_ECMD
    } seq_state_e;

    typedef struct packed {
        logic       is_key_a;
        logic       is_key_b;
        logic       at_cmd_addr;
        logic [7:0] code;
    } wr_match_t;

endpackage

// File: rtl/cmdseq_match.sv
module cmdseq_match
    import cmdseq_pkg::*;
(
    input  logic [KEY_W-1:0] addr_lo,
    input  logic [7:0]       data_lo,
    output wr_match_t        m
);
    always_comb begin
        m.at_cmd_addr = (addr_lo == KEY_ADDR_A);
        m.is_key_a    = (addr_lo == KEY_ADDR_A) && (data_lo == CODE_KEY_A);
        m.is_key_b    = (addr_lo == KEY_ADDR_B) && (data_lo == CODE_KEY_B);
        m.code        = data_lo;
    end
endmodule

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int SECTOR_LSB = 11,
    parameter int BLOCK_LSB  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              busy,
    input  wr_match_t         m,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    output logic              op_start,
    output op_kind_e          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data,
    output mode_e             mode
);
    localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECTOR_LSB;
    localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLOCK_LSB;

    seq_state_e state_q, state_d;
    mode_e      mode_q, mode_d;
    op_kind_e   launch;
    logic       accept;

    assign accept = wr_en && !busy;
    assign mode   = mode_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MD_READ;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    // next state and launch decision
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        launch  = OPK_NONE;
        if (accept) begin
            state_d = ST_IDLE;
            mode_d  = MD_READ;
            unique case (state_q)
                ST_IDLE: if (m.is_key_a) begin
                    state_d = ST_KEY1;
                    mode_d  = mode_q;
                end
                ST_KEY1: if (m.is_key_b) begin
                    state_d = ST_CMD;
                    mode_d  = mode_q;
                end
                ST_CMD: if (m.at_cmd_addr) begin
                    case (m.code)
                        CODE_PROG: begin
                            state_d = ST_PROG;
                            mode_d  = mode_q;
                        end
                        CODE_ERASE: begin
                            state_d = ST_EKEY0;
                            mode_d  = mode_q;
                        end
                        CODE_ID:  mode_d = MD_ID;
                        CODE_CFI: mode_d = MD_CFI;
                        default:  mode_d = MD_READ;
                    endcase
                end
                ST_PROG: launch = OPK_PROG;
                ST_EKEY0: if (m.is_key_a) begin
                    state_d = ST_EKEY1;
                    mode_d  = mode_q;
                end
                ST_EKEY1: if (m.is_key_b) begin
                    state_d = ST_ECMD;
                    mode_d  = mode_q;
                end
                ST_ECMD: begin
                    if (m.code == CODE_SECT)
                        launch = OPK_SECTOR;
                    else if (m.code == CODE_BLK)
                        launch = OPK_BLOCK;
                    else if (m.code == CODE_CHIP && m.at_cmd_addr)
                        launch = OPK_CHIP;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // launch outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_start <= 1'b0;
            op_kind  <= OPK_NONE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            op_start <= (launch != OPK_NONE);
            if (launch != OPK_NONE) begin
                op_kind <= launch;
                op_data <= wr_data;
                unique case (launch)
                    OPK_SECTOR: op_addr <= wr_addr & SECT_MASK;
                    OPK_BLOCK:  op_addr <= wr_addr & BLK_MASK;
                    OPK_CHIP:   op_addr <= '0;
                    default:    op_addr <= wr_addr;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmdseq_idsel.sv
module cmdseq_idsel
    import cmdseq_pkg::*;
#(
    parameter logic [15:0] DEV_CODE = 16'h2781
) (
    input  mode_e       mode,
    input  logic        rd_a0,
    output logic [15:0] id_word
);
    always_comb begin
        if (mode == MD_ID)
            id_word = rd_a0 ? DEV_CODE : MFR_CODE;
        else
            id_word = 16'h0000;
    end
endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
    import cmdseq_pkg::*;
#(
    parameter int          ADDR_W     = 19,
    parameter int          SECTOR_LSB = 11,
    parameter int          BLOCK_LSB  = 15,
    parameter logic [15:0] DEV_CODE   = 16'h2781
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              busy,
    input  logic              rd_a0,
    output logic              op_start,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data,
    output logic              mode_read,
    output logic              mode_id,
    output logic              mode_cfi,
    output logic [15:0]       id_word
);
    wr_match_t m;
    op_kind_e  kind;
    mode_e     mode;

    cmdseq_match u_match (
        .addr_lo (wr_addr[KEY_W-1:0]),
        .data_lo (wr_data[7:0]),
        .m       (m)
    );

    cmdseq_fsm #(
        .ADDR_W     (ADDR_W),
        .SECTOR_LSB (SECTOR_LSB),
        .BLOCK_LSB  (BLOCK_LSB)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .busy     (busy),
        .m        (m),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .op_start (op_start),
        .op_kind  (kind),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .mode     (mode)
    );

    cmdseq_idsel #(.DEV_CODE(DEV_CODE)) u_idsel (
        .mode    (mode),
        .rd_a0   (rd_a0),
        .id_word (id_word)
    );

    assign op_kind   = kind;
    assign mode_read = (mode == MD_READ);
    assign mode_id   = (mode == MD_ID);
    assign mode_cfi  = (mode == MD_CFI);
endmodule

// File: rtl/cmdseq_checks.sv
module cmdseq_checks #(
    parameter int          ADDR_W     = 19,
    parameter int          SECTOR_LSB = 11,
    parameter logic [15:0] DEV_CODE   = 16'h2781
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              busy,
    input logic [15:0]       wr_data,
    input logic              rd_a0,
    input logic              op_start,
    input logic [2:0]        op_kind,
    input logic [ADDR_W-1:0] op_addr,
    input logic [15:0]       op_data,
    input logic              mode_read,
    input logic              mode_id,
    input logic              mode_cfi,
    input logic [15:0]       id_word
);
    // R12
    mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({mode_read, mode_id, mode_cfi}));

    // R12
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> (!op_start && $stable({mode_read, mode_id, mode_cfi})));

    // R10
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> ($past(wr_en) && !$past(busy)));

    // R2
    prog_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == 3'd1) |-> (op_data == $past(wr_data)));

    // R4
    sector_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == 3'd2) |-> (op_addr[SECTOR_LSB-1:0] == '0));

    // R7
    id_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_id && rd_a0) |-> (id_word == DEV_CODE));

    // R7
    id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_id |-> (id_word == 16'h0000));
endmodule

bind unlock_seq_decoder cmdseq_checks #(
    .ADDR_W     (ADDR_W),
    .SECTOR_LSB (SECTOR_LSB),
    .DEV_CODE   (DEV_CODE)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .busy      (busy),
    .wr_data   (wr_data),
    .rd_a0     (rd_a0),
    .op_start  (op_start),
    .op_kind   (op_kind),
    .op_addr   (op_addr),
    .op_data   (op_data),
    .mode_read (mode_read),
    .mode_id   (mode_id),
    .mode_cfi  (mode_cfi),
    .id_word   (id_word)
);

// File: tb/tb_unlock_seq_decoder.sv
module tb_unlock_seq_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 19;
    localparam logic [15:0] DEV = 16'h2781;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [15:0]       wr_data = '0;
    logic              busy = 1'b0;
    logic              rd_a0 = 1'b0;
    logic              op_start;
    logic [2:0]        op_kind;
    logic [ADDR_W-1:0] op_addr;
    logic [15:0]       op_data;
    logic              mode_read, mode_id, mode_cfi;
    logic [15:0]       id_word;

    unlock_seq_decoder #(.ADDR_W(ADDR_W), .DEV_CODE(DEV)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .rd_a0(rd_a0),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
        .op_data(op_data), .mode_read(mode_read), .mode_id(mode_id),
        .mode_cfi(mode_cfi), .id_word(id_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    // behavioural reference model
    int qa[$];
    int qd[$];
    int m_mode = 0;
    bit e_start = 0;
    int e_kind = 0;
    int e_addr = 0;
    int e_data = 0;

    function automatic bit lo_is(int a, int d, int wa, int wd);
        return ((a & 'h7FFF) == wa) && ((d & 'hFF) == wd);
    endfunction

    task automatic launch(int k, int a, int d);
        e_start = 1;
        e_kind  = k;
        e_addr  = a;
        e_data  = d;
    endtask

    task automatic model_write(int a, int d);
        int  c;
        int  n;
        bit  at5;
        bit  keep;
        int  new_mode;
        c = d & 'hFF;
        at5 = ((a & 'h7FFF) == 'h5555);
        keep = 0;
        new_mode = 0;
        qa.push_back(a);
        qd.push_back(d);
        n = qa.size();
        if (n == 1) keep = lo_is(a, d, 'h5555, 'hAA);
        else if (n == 2) keep = lo_is(a, d, 'h2AAA, 'h55);
        else if (n == 3) begin
            if (at5 && (c == 'hA0 || c == 'h80)) keep = 1;
            else if (at5 && c == 'h90) new_mode = 1;
            else if (at5 && c == 'h98) new_mode = 2;
        end else if (n == 4) begin
            if ((qd[2] & 'hFF) == 'hA0) launch(1, a, d);
            else keep = lo_is(a, d, 'h5555, 'hAA);
        end else if (n == 5) keep = lo_is(a, d, 'h2AAA, 'h55);
        else begin
            if (c == 'h30) launch(2, a & ~'h7FF, d);
            else if (c == 'h50) launch(3, a & ~'h7FFF, d);
            else if (c == 'h10 && at5) launch(4, 0, d);
        end
        if (!keep) begin
            m_mode = new_mode;
            qa.delete();
            qd.delete();
        end
    endtask

    always @(posedge clk) begin
        e_start = 0;
        if (!rst_n) begin
            m_mode = 0; qa.delete(); qd.delete();
            e_kind = 0; e_addr = 0; e_data = 0;
        end else if (wr_en && !busy) begin
            model_write(int'(wr_addr), int'(wr_data));
        end
    end

    task automatic chk(string req, bit ok, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always begin
        @(posedge clk);
        #3;
        if (rst_n) begin
            logic [2:0]  em;
            logic [15:0] eid;
            em  = (m_mode == 1) ? 3'b010 : (m_mode == 2) ? 3'b001 : 3'b100;
            eid = (m_mode == 1) ? (rd_a0 ? DEV : 16'h00BF) : 16'h0000;
            chk(cur_req, op_start == e_start, "op_start", op_start, e_start);
            chk(cur_req, int'(op_kind) == e_kind, "op_kind", op_kind, e_kind);
            chk(cur_req, int'(op_addr) == e_addr, "op_addr", op_addr, e_addr);
            chk(cur_req, int'(op_data) == e_data, "op_data", op_data, e_data);
            chk(cur_req, {mode_read, mode_id, mode_cfi} == em, "modes",
                {mode_read, mode_id, mode_cfi}, em);
            chk(cur_req, id_word == eid, "id_word", id_word, eid);
            // R12 one-hot mode flags
            chk("R12", $countones({mode_read, mode_id, mode_cfi}) == 1, "onehot",
                {mode_read, mode_id, mode_cfi}, 1);
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a[ADDR_W-1:0];
        wr_data = d[15:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic unlock();
        wr('h5555, 'hAA);
        wr('h2AAA, 'h55);
    endtask

    task automatic erase_key();
        unlock();
        wr('h5555, 'h80);
        unlock();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", !op_start && mode_read && !mode_id && !mode_cfi, "reset modes",
            {op_start, mode_read, mode_id, mode_cfi}, 4'b0100);
        chk("R1", op_kind == 0 && op_addr == 0 && op_data == 0, "reset op regs",
            op_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 program
        cur_req = "R2";
        unlock();
        wr('h5555, 'hA0);
        wr('h41234, 'hBEEF);
        chk("R2", op_start && op_kind == 1, "prog start/kind", {op_start, op_kind}, 4'b1001);
        chk("R2", op_addr == 'h41234 && op_data == 'hBEEF, "prog addr", op_addr, 'h41234);
        @(negedge clk);
        chk("R12", !op_start, "pulse width", op_start, 0);

        // R3 upper bits ignored in matching
        cur_req = "R3";
        wr('h7D555, 'h12AA);
        wr('h3AAAA, 'hFF55);
        wr('h45555, 'h33A0);
        wr('h00010, 'h0001);
        chk("R3", op_start && op_kind == 1 && op_addr == 'h10, "masked keys", op_addr, 'h10);

        // R4 sector erase
        cur_req = "R4";
        erase_key();
        wr('h34ABC, 'h0030);
        chk("R4", op_start && op_kind == 2 && op_addr == 'h34800, "sector", op_addr, 'h34800);

        // R5 block erase
        cur_req = "R5";
        erase_key();
        wr('h5ABCD, 'h0050);
        chk("R5", op_start && op_kind == 3 && op_addr == 'h58000, "block", op_addr, 'h58000);

        // R6 chip erase and wrong-address abort
        cur_req = "R6";
        erase_key();
        wr('h5555, 'h0010);
        chk("R6", op_start && op_kind == 4 && op_addr == 0, "chip", op_addr, 0);
        erase_key();
        wr('h01234, 'h0010);
        chk("R6", !op_start && mode_read, "chip bad addr", op_start, 0);

        // R7 ID mode
        cur_req = "R7";
        unlock();
        wr('h5555, 'h90);
        chk("R7", mode_id, "id entry", mode_id, 1);
        rd_a0 = 1'b0;
        #1;
        chk("R7", id_word == 'h00BF, "mfr word", id_word, 'h00BF);
        rd_a0 = 1'b1;
        #1;
        chk("R7", id_word == DEV, "dev word", id_word, DEV);

        // R9 single-write exit
        cur_req = "R9";
        wr('h00123, 'hF0);
        chk("R9", mode_read, "short exit", mode_read, 1);
        chk("R7", id_word == 0, "id_word outside id", id_word, 0);

        // R8 CFI entry, R9 long exit
        cur_req = "R8";
        unlock();
        wr('h5555, 'h98);
        chk("R8", mode_cfi, "cfi entry", mode_cfi, 1);
        cur_req = "R9";
        unlock();
        chk("R9", mode_cfi, "cfi held mid-exit", mode_cfi, 1);
        wr('h5555, 'hF0);
        chk("R9", mode_read, "long exit", mode_read, 1);

        // R10 mismatches
        cur_req = "R10";
        unlock();
        wr('h5555, 'h77);
        wr('h00100, 'h1234);
        chk("R10", !op_start && mode_read, "bad cmd", op_start, 0);
        wr('h5555, 'hAA);
        wr('h5555, 'hAA);
        wr('h2AAA, 'h55);
        wr('h5555, 'hA0);
        wr('h00200, 'h4321);
        chk("R10", !op_start, "restart required", op_start, 0);
        unlock();
        wr('h5555, 'h90);
        wr('h00000, 'h0012);
        chk("R10", mode_read, "abort in id", mode_read, 1);

        // R11 busy blocks writes
        cur_req = "R11";
        unlock();
        wr('h5555, 'h90);
        busy = 1'b1;
        wr('h00005, 'hF0);
        chk("R11", mode_id, "exit ignored busy", mode_id, 1);
        busy = 1'b0;
        wr('h00005, 'hF0);
        chk("R11", mode_read, "exit after busy", mode_read, 1);
        unlock();
        wr('h5555, 'hA0);
        busy = 1'b1;
        wr('h00111, 'hAAAA);
        chk("R11", !op_start, "prog blocked", op_start, 0);
        busy = 1'b0;
        wr('h00222, 'h5A5A);
        chk("R11", op_start && op_addr == 'h222 && op_data == 'h5A5A, "prog resumes",
            op_addr, 'h222);

        cur_req = "R12";
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule